// File: doc/BRIEF.md
# Programmable Prescaled Baud-Rate Generator Channel

This block is one divider channel of a bank of baud-rate generators. A single 32-bit control word selects the tick source, an optional fixed divide-by-16 stage, and a 12-bit count. The channel divides the chosen tick stream by that count and toggles a square-wave output at each terminal count. Every tick source is a rising edge of either the system clock, which serves as the internal reference, or one of the synchronized external pins.

Software writes the control word over a plain write port and can read it back at any time. To restart a channel cleanly, software writes the word with the restart bit set and then writes it again with the restart bit clear. A new count written while the channel is running is not applied in the middle of a half-period: it is picked up at the next terminal count. The parameter `CHAN_IDX` (1 to 8) sets which external pins the channel can see. Channels 3, 4, 7 and 8 use a different pin pair from channels 1, 2, 5 and 6.

Top module: `brg_channel`

## Requirements
- R1: The count field is in bits 12:1 of the control word. A field value N makes the output toggle once every N+1 source ticks, so N=0 toggles on every tick. With the internal source, there is one tick per system clock cycle.
- R2: Bit 0 set inserts a divide-by-16 stage ahead of the counter, which makes the half-period 16×(N+1) ticks.
- R3: The source field is in bits 15:14. Code 0 selects the internal reference, and code 3 behaves exactly like code 0.
- R4: Source codes 1 and 2 select `ext_pin[2]` and `ext_pin[3]` when `CHAN_IDX` is 3, 4, 7 or 8. For any other channel they select `ext_pin[0]` and `ext_pin[1]`. One tick is counted per rising edge of the selected pin.
- R5: Bit 17 is the restart bit. While it is set, the output is low and the divider is cleared. After it is cleared, the first toggle comes N+1 ticks (16×(N+1) with the prescaler on) later.
- R6: Bit 16 is the enable bit. While it is clear, the output holds its level and does not toggle.
- R7: A count rewritten while the channel runs first completes the half-period that is in progress at the old count. All later half-periods use the new count.
- R8: `cfg_rdata` returns the last written control word one cycle after the write. After `rst_n` it reads zero and `brg_out` is low.
- R9: The largest field value, 4095, gives a half-period of 4096 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word |
| ext_pin | input | 4 | Asynchronous external clock pins |
| brg_out | output | 1 | Divided square-wave output |

## Verification
A wrong count or a reload at the wrong time shows as a single output half-period of the wrong length. The length of the half-period that follows the reconfiguration exposes it. A wrong source selection or group mapping changes the spacing by the ratio of the pin periods, which are chosen pairwise distinct, and this is visible within one or two half-periods. A wrong restart or enable gating shows as an output that is high, or that toggles, within a few cycles of the write.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Control word layout
  localparam int CTL_W       = 32;
  localparam int CNT_W       = 12;
  localparam int BIT_PRE16   = 0;
  localparam int CNT_LSB     = 1;
  localparam int SRC_LSB     = 14;
  localparam int BIT_ENABLE  = 16;
  localparam int BIT_RESTART = 17;
  localparam int PRE_RATIO   = 16;
  localparam int NUM_PINS    = 4;

  typedef enum logic [1:0] {
    SRC_REF     = 2'd0,
    SRC_EXT_A   = 2'd1,
    SRC_EXT_B   = 2'd2,
    SRC_REF_ALT = 2'd3
  } src_e;

  typedef struct packed {
    logic             restart;
    logic             enable;
    src_e             src;
    logic [CNT_W-1:0] count;
    logic             pre16;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.pre16   = w[BIT_PRE16];
    c.count   = w[CNT_LSB +: CNT_W];
    c.src     = src_e'(w[SRC_LSB +: 2]);
    c.enable  = w[BIT_ENABLE];
    c.restart = w[BIT_RESTART];
    return c;
  endfunction
endpackage

// File: rtl/brg_src_sel.sv
module brg_src_sel
  import brg_pkg::*;
#(
  parameter int CHAN_IDX    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  src_e                src_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                tick_o
);
  // Channels 3,4,7,8 take the upper pin pair
  localparam bit UPPER_GRP = (((CHAN_IDX - 1) >> 1) & 1) == 1;
  localparam int PIN_A = UPPER_GRP ? 2 : 0;
  localparam int PIN_B = UPPER_GRP ? 3 : 1;

  logic [NUM_PINS-1:0] rise;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i[p]};
    end
    assign rise[p] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

    // An edge detector cannot report two edges in a row
    p_edge_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise[p] |=> !rise[p]);
  end

  always_comb begin
    unique case (src_i)
      SRC_EXT_A: tick_o = enable_i & rise[PIN_A];
      SRC_EXT_B: tick_o = enable_i & rise[PIN_B];
      default:   tick_o = enable_i;
    endcase
  end
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic bypass_n_i,
  input  logic tick_i,
  output logic tick_o
);
  localparam int PW = $clog2(RATIO);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pcnt_q <= '0;
    else if (clr_i)                   pcnt_q <= '0;
    else if (tick_i && bypass_n_i)    pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
  end

  assign tick_o = bypass_n_i ? (tick_i && pcnt_q == LAST) : tick_i;

  // With the prescaler in, output ticks are never back to back
  p_pre_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_n_i && tick_o) |=> !tick_o);
endmodule

// File: rtl/brg_divcnt.sv
module brg_divcnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          tgl_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic          out_q;
  logic          term;

  assign term = tick_i && (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      out_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lim_q <= lim_i;
      out_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      lim_q <= lim_i;   // new count adopted only at terminal count
      out_q <= ~out_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tgl_o = out_q;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(out_q));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !term) |=> $stable(lim_q));
endmodule

// File: rtl/brg_channel.sv
module brg_channel
  import brg_pkg::*;
#(
  parameter int CHAN_IDX    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CTL_W-1:0]    cfg_wdata,
  output logic [CTL_W-1:0]    cfg_rdata,
  input  logic [NUM_PINS-1:0] ext_pin,
  output logic                brg_out
);
  logic [CTL_W-1:0] ctl_q;
  ctl_t             ctl;
  logic             src_tick;
  logic             div_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_wr) ctl_q <= cfg_wdata;
  end

  assign ctl       = decode_ctl(ctl_q);
  assign cfg_rdata = ctl_q;

  brg_src_sel #(
    .CHAN_IDX   (CHAN_IDX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(ctl.enable & ~ctl.restart),
    .src_i   (ctl.src),
    .pin_i   (ext_pin),
    .tick_o  (src_tick)
  );

  brg_prescale #(
    .RATIO(PRE_RATIO)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ctl.restart),
    .bypass_n_i(ctl.pre16),
    .tick_i    (src_tick),
    .tick_o    (div_tick)
  );

  brg_divcnt #(
    .CW(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ctl.restart),
    .tick_i(div_tick),
    .lim_i (ctl.count),
    .tgl_o (brg_out)
  );

  p_restart_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> !brg_out);
  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));
endmodule

// File: tb/test_brg_channel.sv
module test_brg_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  ext_pin = '0;
  logic        brg_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_prev = 0;
  bit mon_on = 1'b0;
  bit prev_out = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  brg_channel #(.CHAN_IDX(3)) i_brg_channel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_pin(ext_pin), .brg_out(brg_out)
  );

  // External pins: periods 4, 8, 6, 10 cycles
  initial begin
    int c[4];
    for (int i = 0; i < 4; i++) c[i] = 0;
    forever begin
      @(negedge clk);
      if (++c[0] == 2) begin ext_pin[0] = ~ext_pin[0]; c[0] = 0; end
      if (++c[1] == 4) begin ext_pin[1] = ~ext_pin[1]; c[1] = 0; end
      if (++c[2] == 3) begin ext_pin[2] = ~ext_pin[2]; c[2] = 0; end
      if (++c[3] == 5) begin ext_pin[3] = ~ext_pin[3]; c[3] = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measure half-periods and compare against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (rst_n && mon_on && brg_out != prev_out) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected toggle", cyc - t_prev, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e >= 0) check((cyc - t_prev) == e, t, cyc - t_prev, e);
        end
        t_prev = cyc;
      end
      prev_out = brg_out;
    end
  end

  function automatic logic [31:0] mk(input int n, input bit p16, input int src,
                                     input bit en, input bit rs);
    logic [31:0] w;
    w = '0;
    w[0] = p16;
    w[12:1] = n[11:0];
    w[15:14] = src[1:0];
    w[16] = en;
    w[17] = rs;
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input int e, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic start(input int n, input bit p16, input int src);
    mon_on = 1'b0;
    wr(mk(n, p16, src, 1'b1, 1'b1));
    wr(mk(n, p16, src, 1'b1, 1'b0));
    t_prev = cyc;
    mon_on = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(cfg_rdata == 0, "R8 reset rdata", cfg_rdata, 0);
    check(brg_out == 1'b0, "R8 reset out", brg_out, 0);

    // R1: internal source, N=5
    push(6, 3, "R1 half-period N=5");
    start(5, 1'b0, 0);
    check(cfg_rdata == mk(5, 1'b0, 0, 1'b1, 1'b0), "R8 readback", cfg_rdata,
          mk(5, 1'b0, 0, 1'b1, 1'b0));
    drain();

    // R1: N=0 toggles every cycle
    push(1, 4, "R1 half-period N=0");
    start(0, 1'b0, 0);
    drain();

    // R3: source code 3 behaves as internal
    push(3, 3, "R3 src code 3 N=2");
    start(2, 1'b0, 3);
    drain();

    // R2: prescaler
    push(48, 2, "R2 prescaled N=2");
    start(2, 1'b1, 0);
    drain();

    // R9: largest count
    push(4096, 1, "R9 N=4095");
    start(4095, 1'b0, 0);
    drain();

    // R4: channel 3 maps code 1 to pin 2 (period 6)
    push(-1, 1, "R4 first");
    push(12, 2, "R4 src1 pin2");
    start(1, 1'b0, 1);
    drain();

    // R4: code 2 maps to pin 3 (period 10)
    push(-1, 1, "R4 first");
    push(10, 2, "R4 src2 pin3");
    start(0, 1'b0, 2);
    drain();

    // R7: count rewritten mid-period
    push(4, 2, "R7 old count");
    start(3, 1'b0, 0);
    drain();
    push(4, 1, "R7 period in progress");
    push(8, 2, "R7 new count");
    wr(mk(7, 1'b0, 0, 1'b1, 1'b0));
    drain();

    // R6: enable clear holds the output
    push(5, 2, "R6 running");
    start(4, 1'b0, 0);
    drain();
    wr(mk(4, 1'b0, 0, 1'b0, 1'b0));
    begin
      bit held;
      held = brg_out;
      repeat (40) @(negedge clk);
      check(brg_out == held, "R6 output held", brg_out, held);
    end
    push(-1, 1, "R6 resume");
    push(5, 2, "R6 resumed");
    wr(mk(4, 1'b0, 0, 1'b1, 1'b0));
    drain();

    // R5: restart bit forces low and holds
    mon_on = 1'b0;
    wr(mk(4, 1'b0, 0, 1'b1, 1'b1));
    @(negedge clk);
    check(brg_out == 1'b0, "R5 restart low", brg_out, 0);
    repeat (20) @(negedge clk);
    check(brg_out == 1'b0, "R5 restart held low", brg_out, 0);
    push(5, 2, "R5 first after release");
    wr(mk(4, 1'b0, 0, 1'b1, 1'b0));
    t_prev = cyc;
    mon_on = 1'b1;
    drain();

    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule